// File: doc/BRIEF.md
# Clock-Configuration Register Slave on I2C

This block is the serial control port of a clock generator. It watches SCL and SDA on an oversampled system clock and pulls SDA low through an output enable. It holds five configuration bytes that drive the rest of the clock chip: one function byte and four output-enable bytes.

A host writes the bytes as a block. The host sends the write address, then a command byte and a count byte that the block acknowledges and throws away, then data bytes that fill byte 0 upward. A host reads the bytes as a block as well. After the read address, the block returns a fixed byte count, then bytes 0 to 4, then a read-only byte that shows the select pins as they were captured after reset.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: SCL and SDA each pass through a two-flop synchronizer and a filter that accepts a new level only after FILT_LEN (default 3) equal samples. A pulse on SDA shorter than that, while SCL is high, starts nothing and stops nothing.
- R2: The 8-bit address 0xD2 (write) and 0xD3 (read) are acknowledged. Any other address gets no acknowledge, and every byte after it is ignored and left unacknowledged until the next start condition.
- R3: In a write, the two bytes that follow the address are acknowledged, and their contents are not stored anywhere.
- R4: Write data fills byte 0, then byte 1, and so on, one byte at a time. A stop after any complete byte ends the transfer, and the bytes already written keep their new values. cfg_o carries byte n on bits [8n+7:8n].
- R5: Data bytes written past byte 4 are acknowledged and discarded.
- R6: A read returns 0x06 first, then bytes 0 to 4, then byte 5, each sent MSB first.
- R7: After reset, byte 0 is 0x00 and bytes 1 to 4 are 0xFF. sda_oe is low.
- R8: Byte 5 reads as {sel_i[3:0], 4'b0000}. sel_i is captured in the first clock after reset is released, and later changes on sel_i do not change the value read back.
- R9: When the host does not acknowledge a read byte, the block releases SDA and goes idle. The next start condition is served normally.
- R10: The block changes sda_oe only while the filtered SCL is low.
- R11: A start condition (SDA falls while SCL is high) begins a new address phase from any state, including a repeated start inside a transfer. A stop condition (SDA rises while SCL is high) returns the block to idle. Both release SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | Drives SDA low when 1 |
| sel_i | input | 4 | Select pin levels, shown in bits 7:4 of the read-only byte |
| cfg_o | output | 40 | Configuration bytes 0 to 4, byte n on bits [8n+7:8n] |

## Verification
The block-write path is run with a table of frames that carry zero, one, two, five and six data bytes. These sizes separate three behaviours: a stop that comes early, a full fill of the bank, and an overflow byte that must be acknowledged but dropped. Each write is followed by a full block read, which confirms the leading count, the MSB-first bit order and the latched select byte. Directed frames cover four more cases, each of which tells a correct response apart from a specific fault: a foreign address (which must not be acknowledged), a one-cycle SDA glitch (which must not be taken as a start or stop), a host NACK partway through a read, and a repeated start that turns a write into a read.

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave #(
  parameter int         FILT_LEN  = 3,
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter logic [7:0] COUNT_VAL = 8'h06
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [3:0]  sel_i,
  output logic [39:0] cfg_o
);
  localparam logic [2:0] S_IDLE = 3'd0, S_RX = 3'd1, S_RXACK = 3'd2, S_TX = 3'd3, S_TXACK = 3'd4;

  logic [1:0]          scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic                scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h  <= {scl_h[FILT_LEN-2:0], scl_sy[1]};
      sda_h  <= {sda_h[FILT_LEN-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end

  logic scl_rise, scl_fall, start_c, stop_c;
  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  logic [2:0]      st, idx;
  logic [3:0]      bitcnt, sel_q;
  logic [7:0]      shreg, tx_next;
  logic            addr_ph, rd_mode, ack_q, sel_done;
  logic [4:0][7:0] regs;

  always_comb
    case (idx)
      3'd0:    tx_next = COUNT_VAL;
      3'd6:    tx_next = {sel_q, 4'h0};
      3'd7:    tx_next = 8'h00;
      default: tx_next = regs[idx - 3'd1];
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; shreg <= '0; idx <= '0;
      addr_ph <= 1'b0; rd_mode <= 1'b0; ack_q <= 1'b0;
      sel_q <= '0; sel_done <= 1'b0;
      regs <= {{4{8'hFF}}, 8'h00};
    end else begin
      if (!sel_done) begin
        sel_q    <= sel_i;
        sel_done <= 1'b1;
      end
      if (start_c) begin
        st <= S_RX; bitcnt <= '0; idx <= '0;
        addr_ph <= 1'b1; rd_mode <= 1'b0; ack_q <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; ack_q <= 1'b0;
      end else
        case (st)
          S_RX:
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_f};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (addr_ph) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  ack_q <= 1'b1; rd_mode <= shreg[0]; st <= S_RXACK;
                end else st <= S_IDLE;
              end else begin
                ack_q <= 1'b1; st <= S_RXACK;
                if (idx >= 3'd2 && idx <= 3'd6) regs[idx - 3'd2] <= shreg;
                if (idx != 3'd7) idx <= idx + 3'd1;
              end
            end
          S_RXACK:
            if (scl_fall) begin
              ack_q <= 1'b0; addr_ph <= 1'b0;
              if (addr_ph && rd_mode) begin
                shreg <= tx_next; idx <= 3'd1; st <= S_TX;
              end else st <= S_RX;
            end
          S_TX:
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                bitcnt <= '0; st <= S_TXACK;
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          S_TXACK:
            if (scl_rise) ack_q <= ~sda_f;
            else if (scl_fall) begin
              ack_q <= 1'b0;
              if (ack_q) begin
                shreg <= tx_next; st <= S_TX;
                if (idx != 3'd7) idx <= idx + 3'd1;
              end else st <= S_IDLE;
            end
          default: ;
        endcase
    end

  assign sda_oe = (st == S_RXACK && ack_q) || (st == S_TX && !shreg[7]);
  assign cfg_o  = regs;
endmodule

// File: rtl/clkcfg_i2c_slave_chk.sv
module clkcfg_i2c_slave_chk #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_f,
  input logic        scl_d,
  input logic        start_c,
  input logic        stop_c,
  input logic        sda_oe,
  input logic [2:0]  st,
  input logic [3:0]  bitcnt,
  input logic [7:0]  shreg,
  input logic        addr_ph,
  input logic        ack_q,
  input logic [39:0] cfg_o
);
  assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_f && $past(scl_f)) |-> $stable(sda_oe));

  assert_cfg_on_scl_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(!scl_f && scl_d));

  assert_start_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);

  assert_stop_releases_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  assert_no_foreign_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd1 && addr_ph && bitcnt == 4'd8 && !scl_f && scl_d && shreg[7:1] != DEV_ADDR)
      |=> (!sda_oe && st == 3'd0));

  assert_idle_after_nack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd4 && !scl_f && scl_d && !ack_q) |=> (st == 3'd0 && !sda_oe));
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_slave_chk #(.DEV_ADDR(DEV_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .scl_d(scl_d), .start_c(start_c),
  .stop_c(stop_c), .sda_oe(sda_oe), .st(st), .bitcnt(bitcnt), .shreg(shreg),
  .addr_ph(addr_ph), .ack_q(ack_q), .cfg_o(cfg_o)
);

// File: tb/clkcfg_i2c_slave_tb_top.sv
module clkcfg_i2c_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 12;
  localparam logic [39:0] CFG_RST = 40'hFF_FF_FF_FF_00;
  localparam logic [51:0] VEC [0:4] = '{
    {4'd5, 48'hA1_B2_C3_D4_E5_00},
    {4'd2, 48'h5A_3C_00_00_00_00},
    {4'd6, 48'h01_02_03_04_05_66},
    {4'd0, 48'h00_00_00_00_00_00},
    {4'd1, 48'h80_00_00_00_00_00}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, host_low = 1'b0;
  logic [3:0]  sel = 4'b1010;
  logic        sda_oe, sda_line;
  logic [39:0] cfg_o, exp_cfg;
  int checks = 0, errors = 0;

  assign sda_line = ~(host_low | sda_oe);
  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_i2c_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .sel_i(sel), .cfg_o(cfg_o)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    host_low = 1'b0; qw(); scl = 1'b1; qw(); host_low = 1'b1; qw(); scl = 1'b0; qw();
  endtask

  task automatic i2c_stop();
    host_low = 1'b1; qw(); scl = 1'b1; qw(); host_low = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      host_low = ~b[i]; qw(); scl = 1'b1; qw();
      if (i == glitch_bit && b[i]) begin
        host_low = 1'b1; @(negedge clk); host_low = 1'b0;
      end
      qw(); scl = 1'b0; qw();
    end
    host_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda_line; qw(); scl = 1'b0; qw();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    host_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl = 1'b1; qw(); b[i] = sda_line; qw(); scl = 1'b0;
    end
    qw(); host_low = give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    host_low = 1'b0;
  endtask

  task automatic write_frame(input int n, input logic [47:0] data);
    logic ack;
    i2c_start();
    send_byte(8'hD2, -1, ack); chk("R2 write address ack", {39'd0, ack}, 40'd1);
    send_byte(8'hFF, -1, ack); chk("R3 command byte ack", {39'd0, ack}, 40'd1);
    send_byte(8'h55, -1, ack); chk("R3 count byte ack", {39'd0, ack}, 40'd1);
    for (int i = 0; i < n; i++) begin
      send_byte(data[47-8*i -: 8], -1, ack);
      chk(i < 5 ? "R4 data ack" : "R5 overflow ack", {39'd0, ack}, 40'd1);
      if (i < 5) exp_cfg[8*i +: 8] = data[47-8*i -: 8];
    end
    i2c_stop();
  endtask

  task automatic read_all();
    logic ack;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hD3, -1, ack); chk("R2 read address ack", {39'd0, ack}, 40'd1);
    recv_byte(1'b1, b); chk("R6 leading count", {32'd0, b}, 40'h06);
    for (int k = 0; k < 5; k++) begin
      recv_byte(1'b1, b); chk("R6 R10 byte readback msb first", {32'd0, b}, {32'd0, exp_cfg[8*k +: 8]});
    end
    recv_byte(1'b0, b); chk("R8 latched select byte", {32'd0, b}, 40'hA0);
    i2c_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    exp_cfg = CFG_RST;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset config", cfg_o, CFG_RST);
    chk("R7 reset sda release", {39'd0, sda_oe}, 40'd0);
    sel = 4'b0101;
    qw();

    for (int v = 0; v < 5; v++) begin
      write_frame(int'(VEC[v][51:48]), VEC[v][47:0]);
      chk("R3 R4 R5 config after write", cfg_o, exp_cfg);
      read_all();
    end

    i2c_start();
    send_byte(8'hA4, -1, ack); chk("R2 foreign address nack", {39'd0, ack}, 40'd0);
    send_byte(8'h00, -1, ack); chk("R2 ignored after foreign address", {39'd0, ack}, 40'd0);
    i2c_stop();
    chk("R2 config untouched", cfg_o, exp_cfg);

    i2c_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h7E, 6, ack); chk("R1 glitched byte ack", {39'd0, ack}, 40'd1);
    send_byte(8'h11, -1, ack); chk("R1 transfer continues after glitch", {39'd0, ack}, 40'd1);
    i2c_stop();
    exp_cfg[15:0] = 16'h117E;
    chk("R1 glitch ignored config", cfg_o, exp_cfg);

    i2c_start();
    send_byte(8'hD3, -1, ack);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b); chk("R9 byte before nack", {32'd0, b}, {32'd0, exp_cfg[7:0]});
    repeat (3) @(negedge clk);
    chk("R9 sda released after nack", {39'd0, sda_oe}, 40'd0);
    i2c_stop();
    i2c_start();
    send_byte(8'hD3, -1, ack); chk("R9 next transfer ack", {39'd0, ack}, 40'd1);
    recv_byte(1'b0, b); chk("R9 next transfer count", {32'd0, b}, 40'h06);
    i2c_stop();

    i2c_start();
    send_byte(8'hD2, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h00, -1, ack);
    send_byte(8'h42, -1, ack);
    exp_cfg[7:0] = 8'h42;
    i2c_start();
    send_byte(8'hD3, -1, ack); chk("R11 repeated start read ack", {39'd0, ack}, 40'd1);
    recv_byte(1'b1, b); chk("R11 repeated start count", {32'd0, b}, 40'h06);
    recv_byte(1'b0, b); chk("R11 R4 byte0 after repeated start", {32'd0, b}, 40'h42);
    i2c_stop();
    chk("R11 config after repeated start", cfg_o, exp_cfg);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule